// File: doc/BRIEF.md
# Remote-Sense Dither Timing Sequencer

This block generates the timing strobes for a two-wire remote-sense regulation loop. Each dither cycle it first closes the loop on output voltage, then on a reduced current. Meanwhile it tells external track/hold switches when to capture the high voltage, the output current, the low voltage and their difference. The length of the dither cycle is the reference clock divided by a power-of-two ratio chosen by a three-bit select bus. The ratio is only picked up at a cycle boundary, so a cycle is never cut short.

An enable input, normally driven by an undervoltage comparator, starts and stops the sequence. Each time it rises, a soft-correct ramp starts from zero and climbs one step per completed dither cycle until it saturates. An overvoltage flag restarts that ramp. An optional spread mode moves the phase boundaries by a small pseudo-random amount each cycle, in pairs that leave the mean cycle length unchanged. A square wave toggling on every reference edge is available so that an external switching supply can lock to it.

Top module: `dither_seq`

## Requirements
- R1: During reset and right after it, every phase strobe, `corr_valid_o`, `soft_start_o`, `soft_lvl_o` and `sync_o` are 0.
- R2: While enabled, a cycle runs six phases in fixed order. The strobe bits are: 0 regulate voltage, 1 track high voltage, 2 track current, 3 regulate reduced current, 4 track low voltage, 5 track difference. Phases 0 and 3 last P/4 clocks each and the other four last P/8 each. At most one strobe is high at a time, and each strobe stays low for the first clock of its phase.
- R3: The select code k in 1..7 gives P = 2^(k+3), so code 6 gives 512. Code 0 gives P = 2048. A new code takes effect only at the next cycle boundary.
- R4: Strobe bit 3 is the command that sets the supply to 90% of the current captured in phase 2. It is high only inside phase 3.
- R5: `corr_valid_o` rises at the clock where a phase-5 cycle ends. It stays high while enabled, so the captured difference is used as the correction in the next cycle.
- R6: While `enable_i` is low, all strobes and `corr_valid_o` are low and the sequence waits at the start of phase 0. After enable returns, the sequence restarts there.
- R7: `soft_lvl_o` is 0 while disabled. It steps up by 1 at every completed cycle and saturates at all ones. `soft_start_o` pulses for one clock after `enable_i` rises.
- R8: While `ovp_i` is high, `soft_lvl_o` is held at 0. If enable is high, a rising `ovp_i` gives a one-clock `soft_start_o` pulse, and the ramp then starts again from 0.
- R9: With spread latched at a cycle boundary, phase 0 is lengthened by +j in one cycle and shortened by j in the next.
  - j is the 7-bit LFSR's low six bits ANDed with P/32-1, or with 0 when P < 64.
  - The LFSR uses x^7+x^6+1, has seed 1, and shifts left with feedback bit6 xor bit5.
  - The LFSR advances after each shortened cycle, so |j| < P/32 and each pair of cycles sums to 2P.
  - A cycle without spread, or a disable, makes the next spread cycle a lengthened one.
- R10: `sync_o` toggles on every clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run enable from the undervoltage comparator |
| ovp_i | input | 1 | Overvoltage flag; restarts the soft ramp |
| div_sel_i | input | 3 | Division ratio select code |
| spread_en_i | input | 1 | Enables pseudo-random phase jitter |
| phase_stb_o | output | 6 | One strobe per phase, bit order as in R2 |
| corr_valid_o | output | 1 | Captured difference is valid for use |
| soft_lvl_o | output | 6 | Soft-correct ramp level |
| soft_start_o | output | 1 | One-clock pulse when the ramp restarts |
| sync_o | output | 1 | Square wave for supply synchronisation |

## Verification
The sequence is first run at the shortest ratio, so phase order, gaps and the ramp are seen over many short cycles. A code change made just after a cycle starts separates a reload at the boundary from an immediate one. It also confirms the 512 and 2048 ratios. A spread run started from a known LFSR state expects lengths 1025, 1023, 1026 and 1022, which checks the sign pairing and the LFSR stepping. Random toggling of enable, overvoltage, spread and the select code is then compared clock by clock against a reference model in the bench. This exposes mid-cycle disables and ramp restarts.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    localparam int NPH = 6;

    typedef enum logic [2:0] {
        PH_REG_V   = 3'd0,
        PH_TRK_VH  = 3'd1,
        PH_TRK_I   = 3'd2,
        PH_REG_ILO = 3'd3,
        PH_TRK_VL  = 3'd4,
        PH_TRK_DV  = 3'd5
    } phase_e;

endpackage

// File: rtl/dseq_ratio.sv
module dseq_ratio #(
    parameter int SEL_W     = 3,
    parameter int LOG2_BASE = 3,
    parameter int LQ_W      = 4
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [LQ_W-1:0]  lq_o
);
    localparam int LOG2_TOP = LOG2_BASE + (1 << SEL_W);

    // code 0 selects the longest ratio, others climb from the base
    always_comb begin
        if (sel_i == '0) begin
            lq_o = LQ_W'(LOG2_TOP);
        end else begin
            lq_o = LQ_W'(LOG2_BASE) + LQ_W'(sel_i);
        end
    end

endmodule

// File: rtl/dseq_jitter.sv
module dseq_jitter #(
    parameter int LFSR_W    = 7,
    parameter int CNT_W     = 12,
    parameter int LQ_W      = 4,
    parameter int JIT_SHIFT = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold_i,
    input  logic                    step_i,
    input  logic                    spr_i,
    input  logic [LQ_W-1:0]         lq_i,
    output logic signed [CNT_W:0]   ofs_o
);
    localparam int PICK_W = LFSR_W - 1;

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic              neg;
    } jit_t;

    jit_t st_d, st_q;
    logic [PICK_W-1:0]    mask_c;
    logic [PICK_W-1:0]    pick_c;
    logic signed [CNT_W:0] mag_c;

    always_comb begin
        st_d = st_q;
        // offset bound follows the live ratio: below P/32
        if (lq_i > LQ_W'(JIT_SHIFT)) begin
            mask_c = PICK_W'((1 << (lq_i - LQ_W'(JIT_SHIFT))) - 1);
        end else begin
            mask_c = '0;
        end
        pick_c = st_q.lfsr[PICK_W-1:0] & mask_c;
        mag_c  = $signed((CNT_W+1)'(pick_c));
        if (!spr_i) begin
            ofs_o = '0;
        end else if (st_q.neg) begin
            ofs_o = -mag_c;
        end else begin
            ofs_o = mag_c;
        end

        if (hold_i) begin
            st_d.neg = 1'b0;
        end else if (step_i) begin
            if (spr_i) begin
                st_d.neg = ~st_q.neg;
                // new value only after the shortened half of a pair
                if (st_q.neg) begin
                    st_d.lfsr = {st_q.lfsr[LFSR_W-2:0],
                                 st_q.lfsr[LFSR_W-1] ^ st_q.lfsr[LFSR_W-2]};
                end
            end else begin
                st_d.neg = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lfsr <= LFSR_W'(1);
            st_q.neg  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dseq_soft.sv
module dseq_soft #(
    parameter int SOFT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              ovp_i,
    input  logic              cyc_end_i,
    output logic [SOFT_W-1:0] lvl_o,
    output logic              start_o
);
    typedef struct packed {
        logic              en_p;
        logic              ov_p;
        logic              start;
        logic [SOFT_W-1:0] lvl;
    } soft_t;

    soft_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.en_p  = en_i;
        st_d.ov_p  = ovp_i;
        st_d.start = (en_i && !st_q.en_p) || (en_i && ovp_i && !st_q.ov_p);
        if (!en_i || ovp_i) begin
            st_d.lvl = '0;
        end else if (cyc_end_i && (st_q.lvl != '1)) begin
            st_d.lvl = st_q.lvl + SOFT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o   = st_q.lvl;
    assign start_o = st_q.start;

endmodule

// File: rtl/dither_seq.sv
module dither_seq
    import dseq_pkg::*;
#(
    parameter int SEL_W     = 3,
    parameter int LOG2_BASE = 3,
    parameter int SOFT_W    = 6,
    parameter int LFSR_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              ovp_i,
    input  logic [SEL_W-1:0]  div_sel_i,
    input  logic              spread_en_i,
    output logic [NPH-1:0]    phase_stb_o,
    output logic              corr_valid_o,
    output logic [SOFT_W-1:0] soft_lvl_o,
    output logic              soft_start_o,
    output logic              sync_o
);
    localparam int LOG2_TOP = LOG2_BASE + (1 << SEL_W);
    localparam int CNT_W    = LOG2_TOP + 1;
    localparam int LQ_W     = $clog2(LOG2_TOP + 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] tc;
        logic [LQ_W-1:0]  lq;
        logic             spr;
        logic             vld;
        logic             syn;
    } seq_t;

    seq_t st_d, st_q;

    logic [LQ_W-1:0]       lq_sel_c;
    logic signed [CNT_W:0] ofs_c;
    logic [CNT_W-1:0]      quarter_c;
    logic [CNT_W-1:0]      eighth_c;
    logic [CNT_W-1:0]      plen_c;
    logic                  last_c;
    logic                  cyc_end_c;

    dseq_ratio #(
        .SEL_W     (SEL_W),
        .LOG2_BASE (LOG2_BASE),
        .LQ_W      (LQ_W)
    ) u_ratio (
        .sel_i (div_sel_i),
        .lq_o  (lq_sel_c)
    );

    dseq_jitter #(
        .LFSR_W (LFSR_W),
        .CNT_W  (CNT_W),
        .LQ_W   (LQ_W)
    ) u_jitter (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (!enable_i),
        .step_i (cyc_end_c),
        .spr_i  (st_q.spr),
        .lq_i   (st_q.lq),
        .ofs_o  (ofs_c)
    );

    dseq_soft #(
        .SOFT_W (SOFT_W)
    ) u_soft (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (enable_i),
        .ovp_i     (ovp_i),
        .cyc_end_i (cyc_end_c),
        .lvl_o     (soft_lvl_o),
        .start_o   (soft_start_o)
    );

    // phase length from the ratio latched for this cycle
    always_comb begin
        quarter_c = CNT_W'(1) << (st_q.lq - LQ_W'(2));
        eighth_c  = CNT_W'(1) << (st_q.lq - LQ_W'(3));
        case (st_q.ph)
            PH_REG_V:   plen_c = CNT_W'($signed({1'b0, quarter_c}) + ofs_c);
            PH_REG_ILO: plen_c = quarter_c;
            default:    plen_c = eighth_c;
        endcase
        last_c    = (st_q.tc == plen_c - CNT_W'(1));
        cyc_end_c = enable_i && last_c && (st_q.ph == PH_TRK_DV);
    end

    always_comb begin
        st_d     = st_q;
        st_d.syn = ~st_q.syn;
        if (!enable_i) begin
            st_d.ph  = PH_REG_V;
            st_d.tc  = '0;
            st_d.vld = 1'b0;
            st_d.lq  = lq_sel_c;
            st_d.spr = spread_en_i;
        end else if (last_c) begin
            st_d.tc = '0;
            if (st_q.ph == PH_TRK_DV) begin
                st_d.ph  = PH_REG_V;
                st_d.vld = 1'b1;
                st_d.lq  = lq_sel_c;
                st_d.spr = spread_en_i;
            end else begin
                st_d.ph = phase_e'(st_q.ph + 3'd1);
            end
        end else begin
            st_d.tc = st_q.tc + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph  <= PH_REG_V;
            st_q.tc  <= '0;
            st_q.lq  <= LQ_W'(LOG2_TOP);
            st_q.spr <= 1'b0;
            st_q.vld <= 1'b0;
            st_q.syn <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // first clock of each phase is the switch gap
    for (genvar k = 0; k < NPH; k++) begin : g_stb
        assign phase_stb_o[k] = (st_q.ph == phase_e'(k)) && (st_q.tc != '0);
    end

    assign corr_valid_o = st_q.vld;
    assign sync_o       = st_q.syn;

endmodule

// File: rtl/dseq_chk.sv
module dseq_chk #(
    parameter int SOFT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable_i,
    input logic              ovp_i,
    input logic [5:0]        phase_stb_o,
    input logic              corr_valid_o,
    input logic [SOFT_W-1:0] soft_lvl_o,
    input logic              sync_o
);
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase_stb_o));

    p_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_stb_o != '0) |=> (phase_stb_o == $past(phase_stb_o)) || (phase_stb_o == '0));

    p_valid_after_dv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(corr_valid_o) |-> $past(phase_stb_o[5]));

    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (phase_stb_o == '0) && !corr_valid_o);

    p_ramp_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_lvl_o == $past(soft_lvl_o)) ||
        (soft_lvl_o == $past(soft_lvl_o) + SOFT_W'(1)) ||
        (soft_lvl_o == '0));

    p_ovp_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_i |=> (soft_lvl_o == '0));

    p_sync_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sync_o != $past(sync_o)));

endmodule

bind dither_seq dseq_chk #(.SOFT_W(SOFT_W)) u_chk (.*);

// File: tb/dither_seq_test.sv
module dither_seq_test;
    localparam int CLK_NS    = 10;
    localparam int SEL_W     = 3;
    localparam int LOG2_BASE = 3;
    localparam int SOFT_W    = 6;
    localparam int LOG2_TOP  = LOG2_BASE + (1 << SEL_W);
    localparam int LVL_MAX   = (1 << SOFT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             ovp = 1'b0;
    logic             spr = 1'b0;
    logic [SEL_W-1:0] sel = 3'd1;
    logic [5:0]        stb;
    logic              vld;
    logic [SOFT_W-1:0] lvl;
    logic              st;
    logic              syn;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    dither_seq uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (en),
        .ovp_i        (ovp),
        .div_sel_i    (sel),
        .spread_en_i  (spr),
        .phase_stb_o  (stb),
        .corr_valid_o (vld),
        .soft_lvl_o   (lvl),
        .soft_start_o (st),
        .sync_o       (syn)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int log2_of(input int code);
        return (code == 0) ? LOG2_TOP : LOG2_BASE + code;
    endfunction

    function automatic int jmask(input int lq);
        return (lq > 5) ? (1 << (lq - 5)) - 1 : 0;
    endfunction

    function automatic int plen(input int ph, input int lq, input int d);
        if (ph == 0) return (1 << (lq - 2)) + d;
        if (ph == 3) return (1 << (lq - 2));
        return (1 << (lq - 3));
    endfunction

    // reference model built from the requirements
    int       m_ph = 0, m_tc = 0, m_lq = LOG2_TOP, m_lvl = 0;
    bit       m_spr = 0, m_vld = 0, m_syn = 0, m_enp = 0, m_ovpp = 0, m_st = 0, m_sgn = 0;
    bit [6:0] m_lfsr = 7'd1;

    always @(posedge clk) begin
        int  d, len;
        bit  last, cend;
        if (!rst_n) begin
            m_ph = 0; m_tc = 0; m_lq = LOG2_TOP; m_lvl = 0; m_spr = 0; m_vld = 0;
            m_syn = 0; m_enp = 0; m_ovpp = 0; m_st = 0; m_sgn = 0; m_lfsr = 7'd1;
        end else begin
            d = 0;
            if (m_spr) begin
                d = int'(m_lfsr[5:0]) & jmask(m_lq);
                if (m_sgn) d = -d;
            end
            len  = plen(m_ph, m_lq, d);
            last = (m_tc == len - 1);
            cend = en && last && (m_ph == 5);
            m_st = (en && !m_enp) || (en && ovp && !m_ovpp);
            if (!en || ovp) m_lvl = 0;
            else if (cend && m_lvl != LVL_MAX) m_lvl = m_lvl + 1;
            m_enp = en; m_ovpp = ovp;
            if (!en) m_sgn = 0;
            else if (cend) begin
                if (m_spr) begin
                    if (m_sgn) m_lfsr = {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
                    m_sgn = !m_sgn;
                end else m_sgn = 0;
            end
            if (!en) begin
                m_ph = 0; m_tc = 0; m_vld = 0; m_lq = log2_of(int'(sel)); m_spr = spr;
            end else if (last) begin
                m_tc = 0;
                if (m_ph == 5) begin
                    m_ph = 0; m_vld = 1; m_lq = log2_of(int'(sel)); m_spr = spr;
                end else m_ph = m_ph + 1;
            end else m_tc = m_tc + 1;
            m_syn = !m_syn;
        end
    end

    // clock-by-clock comparison away from the active edge
    always @(negedge clk) begin
        int exp_stb;
        if (rst_n && !done) begin
            exp_stb = (m_tc != 0) ? (1 << m_ph) : 0;
            if (!m_enp)      check(int'(stb) == exp_stb, "R6 strobes", int'(stb), exp_stb);
            else if (m_ph == 3) check(int'(stb) == exp_stb, "R4 strobes", int'(stb), exp_stb);
            else             check(int'(stb) == exp_stb, "R2 strobes", int'(stb), exp_stb);
            check(vld == m_vld, "R5 valid", int'(vld), int'(m_vld));
            check(int'(lvl) == m_lvl, "R7 level", int'(lvl), m_lvl);
            check(st == m_st, "R8 start pulse", int'(st), int'(m_st));
            check(syn == m_syn, "R10 sync", int'(syn), int'(m_syn));
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_rise();
        bit p;
        p = stb[0];
        forever begin
            @(negedge clk);
            if (stb[0] && !p) break;
            p = stb[0];
        end
    endtask

    task automatic measure(output int n);
        bit p;
        n = 0;
        p = stb[0];
        forever begin
            @(negedge clk);
            n++;
            if (stb[0] && !p) break;
            p = stb[0];
        end
    endtask

    initial begin
        #(CLK_NS * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, a, b, c, e, seed;
        seed = $urandom(32'd20240);
        // R1: state held in reset
        step(3);
        @(negedge clk);
        check(stb == 6'd0 && !vld && !st, "R1 strobes/valid/start", int'(stb), 0);
        check(lvl == '0 && !syn, "R1 level/sync", int'(lvl), 0);
        #2 rst_n = 1'b1;
        step(2);
        check(stb == 6'd0 && !vld, "R1 after release", int'(stb), 0);

        // R2 R7: shortest ratio, ramp to saturation
        sel = 3'd1;
        step(2);
        en = 1'b1;
        step(16 * 70);
        @(negedge clk);
        check(int'(lvl) == LVL_MAX, "R7 saturation", int'(lvl), LVL_MAX);
        wait_rise();
        measure(n);
        check(n == 16, "R2 cycle length code1", n, 16);

        // R3: reload only at boundary, then 512 and 2048
        wait_rise();
        sel = 3'd6;
        measure(n);
        check(n == 16, "R3 no mid-cycle reload", n, 16);
        measure(n);
        check(n == 512, "R3 code6 ratio", n, 512);
        sel = 3'd0;
        measure(n);
        check(n == 512, "R3 boundary reload", n, 512);
        measure(n);
        check(n == 2048, "R3 code0 ratio", n, 2048);
        sel = 3'd2;
        step(2200);

        // R8: overvoltage restart
        step(1);
        ovp = 1'b1;
        step(3);
        @(negedge clk);
        check(lvl == '0, "R8 level held", int'(lvl), 0);
        step(1);
        ovp = 1'b0;
        step(32 * 4);

        // R6: disable mid-cycle
        step(5);
        en = 1'b0;
        step(4);
        @(negedge clk);
        check(stb == 6'd0 && !vld, "R6 idle outputs", int'(stb), 0);
        check(lvl == '0, "R6 level cleared", int'(lvl), 0);
        step(1);

        // R9: spread from a known generator state
        sel = 3'd7;
        spr = 1'b1;
        step(2);
        en = 1'b1;
        wait_rise();
        measure(a); measure(b); measure(c); measure(e);
        check(a == 1025, "R9 first lengthened cycle", a, 1025);
        check(b == 1023, "R9 paired shortened cycle", b, 1023);
        check(c == 1026, "R9 generator step", c, 1026);
        check(e == 1022, "R9 second pair", e, 1022);
        check(a + b == 2048 && c + e == 2048, "R9 mean preserved", a + b, 2048);

        // random mix against the model
        sel = 3'd1;
        step(1100);
        for (int i = 0; i < 1600; i++) begin
            int r;
            r = int'($urandom % 16);
            en  = (r != 0);
            ovp = (r == 1);
            if (r == 2) sel = SEL_W'(1 + ($urandom % 3));
            if (r == 3) spr = !spr;
            step(1 + int'($urandom % 24));
        end
        ovp = 1'b0;
        step(10);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule